// File: doc/BRIEF.md
# Clock divider setting calculator

This block turns a source clock rate and a wanted output rate into the two divider field values that a two-stage clock divider needs, plus the rate those fields actually give. A caller puts the source rate, the wanted rate and the index of the selected source on the inputs, then pulses `start`. The block is busy for a number of cycles while a shared restoring divider works through its divisions one quotient bit per cycle. It then pulses `done` for a single cycle, and the results stay on the outputs until the next accepted start.

The whole ratio is the ceiling of source rate over wanted rate. Only the designated source (index 3) has a pre-divider in front of the post-divider. For that source, a ratio above 4 is split between a pre-divider that can divide by 1 to 32 and a post-divider that can divide by 1 to 4. Fixed ratio bands choose the post-divider. For every other source, the whole ratio goes to the post-divider. Fields saturate at the largest ratio they can encode. A wanted rate of zero is reported as an error, and no division is run.

Top module: `clkdiv_calc`

## Requirements
- R1: After reset, `done`, `busy` and `err` are 0, both fields are 0 and `achieved` is 0.
- R2: When the source rate is non-zero and the wanted rate is above it, the wanted rate is replaced by the source rate before any division, so the ratio is 1.
- R3: The ratio is the ceiling of source rate over (clamped) wanted rate. A source rate of zero gives a ratio of 1.
- R4: When the source index is not 3, or the ratio is 4 or less, the pre ratio is 1 and the post ratio is the ratio, saturated at 4.
- R5: For source index 3 with a ratio from 5 to 31, the pre ratio equals the ratio and the post ratio is 1.
- R6: For source index 3, ratios 32–63 give post 2, ratios 64–95 give post 3, and ratios of 96 and up give post 4. In each case the pre ratio is the ceiling of ratio over post, saturated at 32.
- R7: `pre_field` (5 bits) is pre ratio minus 1, and `post_field` (2 bits) is post ratio minus 1.
- R8: `achieved` is the source rate divided by the pre ratio with truncation, then divided by the post ratio with truncation.
- R9: A wanted rate of zero sets `err` and gives both fields 0 and `achieved` 0, with `done` high in the cycle after the start.
- R10: `done` is high for exactly one cycle per accepted start. `busy` is high while a calculation runs. Results hold after `done` until the next accepted start.
- R11: A `start` pulse while `busy` is high is ignored: it changes no result and produces no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a calculation |
| parent_rate | input | 32 | Source clock rate, unsigned |
| req_rate | input | 32 | Wanted output rate, unsigned |
| src_sel | input | 2 | Index of the selected source |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| err | output | 1 | Wanted rate was zero |
| pre_field | output | 5 | Pre-divider ratio minus 1 |
| post_field | output | 2 | Post-divider ratio minus 1 |
| achieved | output | 32 | Rate produced by the chosen fields |

## Verification
The assertions assume `start` is a clean, synchronous single-cycle pulse. They also assume the rate inputs are stable in the cycle `start` is sampled. After that cycle, the inputs may change freely, because the block latches what it needs. The bench drives every start at a falling edge and drops it one cycle later. It deliberately changes all inputs and pulses `start` in the middle of a running calculation, to show that such a pulse is dropped. The divider invariant (remainder below a non-zero divisor while busy) relies on the zero-rate case never reaching the divider. The stimulus includes that case to show it is diverted.

// File: rtl/clkdiv_calc.sv
module clkdiv_calc #(
  parameter int W         = 32,
  parameter int SEL_W     = 2,
  parameter int SPLIT_SEL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [W-1:0]     parent_rate,
  input  logic [W-1:0]     req_rate,
  input  logic [SEL_W-1:0] src_sel,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [4:0]       pre_field,
  output logic [1:0]       post_field,
  output logic [W-1:0]     achieved
);
  localparam int CW       = $clog2(W);
  localparam int PRE_MAX  = 32;
  localparam int POST_MAX = 4;

  typedef enum logic [2:0] {S_IDLE, S_TOT, S_SPLIT, S_A1, S_A2} ph_t;

  ph_t             ph_q;
  logic [W-1:0]    par_q, quo_q, rem_q, den_q, ach_q;
  logic [SEL_W-1:0] sel_q;
  logic [CW-1:0]   cnt_q;
  logic [5:0]      pre_q;
  logic [2:0]      post_q;
  logic            err_q, done_q;

  logic [W:0]   trial, diff;
  logic         fits, last;
  logic [W-1:0] quo_nx, rem_nx, ceil_q, tot, clamped;
  logic         do_split, big;
  logic [2:0]   kdiv, post_plain;
  logic [5:0]   pre_sat;

  assign trial   = {rem_q, quo_q[W-1]};
  assign diff    = trial - {1'b0, den_q};
  assign fits    = trial >= {1'b0, den_q};
  assign rem_nx  = fits ? diff[W-1:0] : trial[W-1:0];
  assign quo_nx  = {quo_q[W-2:0], fits};
  assign last    = cnt_q == CW'(W-1);
  assign ceil_q  = quo_nx + W'(rem_nx != '0);
  assign tot     = (ceil_q == '0) ? W'(1) : ceil_q;
  assign clamped = (parent_rate != '0 && req_rate > parent_rate) ? parent_rate : req_rate;

  assign do_split   = (sel_q == SEL_W'(SPLIT_SEL)) && (tot > W'(POST_MAX));
  assign big        = tot >= W'(32);
  assign kdiv       = (tot < W'(64)) ? 3'd2 : (tot < W'(96)) ? 3'd3 : 3'd4;
  assign post_plain = (tot > W'(POST_MAX)) ? 3'(POST_MAX) : tot[2:0];
  assign pre_sat    = (ceil_q > W'(PRE_MAX)) ? 6'(PRE_MAX) : ceil_q[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= S_IDLE;
      par_q  <= '0;
      sel_q  <= '0;
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      pre_q  <= 6'd1;
      post_q <= 3'd1;
      ach_q  <= '0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ph_q == S_IDLE) begin
        if (start) begin
          par_q <= parent_rate;
          sel_q <= src_sel;
          if (req_rate == '0) begin
            err_q  <= 1'b1;
            pre_q  <= 6'd1;
            post_q <= 3'd1;
            ach_q  <= '0;
            done_q <= 1'b1;
          end else begin
            err_q <= 1'b0;
            quo_q <= parent_rate;
            rem_q <= '0;
            den_q <= clamped;
            cnt_q <= '0;
            ph_q  <= S_TOT;
          end
        end
      end else begin
        quo_q <= quo_nx;
        rem_q <= rem_nx;
        cnt_q <= cnt_q + 1'b1;
        if (last) begin
          cnt_q <= '0;
          rem_q <= '0;
          case (ph_q)
            S_TOT: begin
              if (do_split && big) begin
                post_q <= kdiv;
                quo_q  <= tot;
                den_q  <= W'(kdiv);
                ph_q   <= S_SPLIT;
              end else begin
                pre_q  <= do_split ? tot[5:0] : 6'd1;
                post_q <= do_split ? 3'd1 : post_plain;
                quo_q  <= par_q;
                den_q  <= do_split ? tot : W'(1);
                ph_q   <= S_A1;
              end
            end
            S_SPLIT: begin
              pre_q <= pre_sat;
              quo_q <= par_q;
              den_q <= W'(pre_sat);
              ph_q  <= S_A1;
            end
            S_A1: begin
              quo_q <= quo_nx;
              den_q <= W'(post_q);
              ph_q  <= S_A2;
            end
            default: begin
              ach_q  <= quo_nx;
              done_q <= 1'b1;
              ph_q   <= S_IDLE;
            end
          endcase
        end
      end
    end
  end

  assign busy       = ph_q != S_IDLE;
  assign done       = done_q;
  assign err        = err_q;
  assign pre_field  = 5'(pre_q - 6'd1);
  assign post_field = 2'(post_q - 3'd1);
  assign achieved   = ach_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && err |-> pre_field == '0 && post_field == '0 && achieved == '0);
  // R4
  plain_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err && sel_q != SEL_W'(SPLIT_SEL) |-> pre_field == '0);
  // R8
  ach_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !err |-> achieved <= par_q);
  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy || done);
  // R3
  div_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> den_q != '0 && rem_q < den_q);
endmodule

// File: tb/tb_clkdiv_calc.sv
module tb_clkdiv_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] parent_rate = '0, req_rate = '0;
  logic [1:0]  src_sel = '0;
  logic        busy, done, err;
  logic [4:0]  pre_field;
  logic [1:0]  post_field;
  logic [31:0] achieved;

  typedef struct packed {
    logic [7:0]  rid;
    logic        err;
    logic [4:0]  pre;
    logic [1:0]  post;
    logic [31:0] ach;
  } exp_t;

  exp_t q[$];
  exp_t last_exp;
  int checks = 0, fails = 0;

  clkdiv_calc dut (
    .clk(clk), .rst_n(rst_n), .start(start), .parent_rate(parent_rate),
    .req_rate(req_rate), .src_sel(src_sel), .busy(busy), .done(done),
    .err(err), .pre_field(pre_field), .post_field(post_field), .achieved(achieved)
  );

  always #4 clk = ~clk;

  function automatic exp_t model(input longint p, input longint r, input int s, input int rid);
    exp_t e;
    longint tot, pre, post;
    e.rid = 8'(rid);
    if (r == 0) begin
      e.err = 1'b1; e.pre = '0; e.post = '0; e.ach = '0;
      return e;
    end
    if (p != 0 && r > p) r = p;
    tot = (p + r - 1) / r;
    if (tot == 0) tot = 1;
    if (s == 3 && tot > 4) begin
      if (tot < 32) begin pre = tot; post = 1; end
      else begin
        post = (tot < 64) ? 2 : (tot < 96) ? 3 : 4;
        pre = (tot + post - 1) / post;
        if (pre > 32) pre = 32;
      end
    end else begin
      pre = 1;
      post = (tot > 4) ? 4 : tot;
    end
    e.err = 1'b0;
    e.pre = 5'(pre - 1);
    e.post = 2'(post - 1);
    e.ach = 32'((p / pre) / post);
    return e;
  endfunction

  task automatic check(input bit ok, input string what, input int rid, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rid, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) begin
        check(1'b0, "done without pending request", 10, 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        last_exp = e;
        check(err == e.err && pre_field == e.pre && post_field == e.post && achieved == e.ach,
              "result {err,pre,post,ach}", int'(e.rid),
              {err, pre_field, post_field, achieved}, {e.err, e.pre, e.post, e.ach});
      end
    end
  end

  task automatic launch(input longint p, input longint r, input int s);
    @(negedge clk);
    parent_rate = 32'(p); req_rate = 32'(r); src_sel = 2'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input longint p, input longint r, input int s, input int rid);
    q.push_back(model(p, r, s, rid));
    launch(p, r, s);
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!done && !busy && !err && pre_field == 0 && post_field == 0 && achieved == 0,
          "reset outputs", 1, {done, busy, err, pre_field, post_field, achieved}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(24000000, 24000000, 0, 3);     // R3 ratio 1
    run(24000000, 6000000, 0, 4);      // R4 ratio 4
    run(24000000, 5000000, 1, 4);      // R4 ratio 5, post saturates
    run(1000, 140, 3, 5);              // R5 ratio 8 split, R8
    run(1000, 200, 3, 5);              // R5 ratio 5 split
    run(1000, 250, 3, 4);              // R4 ratio 4 on split source
    run(1200000000, 100000000, 3, 5);  // R5 ratio 12
    run(3200, 100, 3, 6);              // R6 ratio 32
    run(6300, 100, 3, 6);              // R6 ratio 63
    run(6400, 100, 3, 6);              // R6 ratio 64
    run(1000, 15, 3, 6);               // R6 ratio 67, truncation R8
    run(9500, 100, 3, 6);              // R6 ratio 95
    run(9600, 100, 3, 6);              // R6 ratio 96
    run(20000, 100, 3, 6);             // R6 pre saturates at 32
    run(64'hFFFFFFFF, 1, 3, 7);        // R7 largest ratio, both fields full
    run(1000, 7, 2, 8);                // R8 plain source ratio 143
    run(5000, 9000, 3, 2);             // R2 clamp
    run(0, 100, 3, 3);                 // R3 zero source rate
    run(1000, 0, 3, 9);                // R9 zero wanted rate
    // R10 results hold after done
    repeat (4) @(negedge clk);
    check(!done && !busy && pre_field == last_exp.pre && post_field == last_exp.post &&
          achieved == last_exp.ach && err == last_exp.err, "hold after done", 10,
          {err, pre_field, post_field, achieved}, {last_exp.err, last_exp.pre, last_exp.post, last_exp.ach});
    // R11 start while busy ignored
    q.push_back(model(1000, 140, 3, 11));
    launch(1000, 140, 3);
    repeat (10) @(negedge clk);
    parent_rate = 32'd77; req_rate = 32'd0; src_sel = 2'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    repeat (200) @(negedge clk);
    // R11 no extra done
    check(q.size() == 0 && !busy, "pending after ignored start", 11, q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule